// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block takes a one-shot command from a register interface (a 4-bit operation code, an erase flag, a word address, a data word and a start strobe), classifies it, and runs it against an on-chip flash array. Only three operations are supported: programming a single word, erasing one aligned page, and erasing the whole general segment. Any other combination of code and erase flag is rejected. A rejected command finishes at once with an error indication and does not touch the array.

An accepted command holds a busy flag for a fixed number of clock cycles, set by a parameter. Word programs use one count and erases use another. This lets the wait time track the flash timing (roughly 48.8 µs per word and 26.5 ms per page) at whatever clock the block runs on. When the count runs out, the block strobes the array and pulses done. Busy drops in that same cycle.

The array model included here behaves like flash. An erased word reads as all ones, and programming can only clear bits. A combinational read port lets software, or a bench, inspect the contents.

Top module: `flash_op_sequencer`

## Requirements
- R1: With erase_i = 1, op_i = 4'b0010 is a page erase, op_i = 4'b1101 is a general-segment erase, and every other code is rejected as a no-op.
- R2: With erase_i = 0, op_i = 4'b0011 programs one word, and every other code (including the row-program code 4'b0001) is rejected as a no-op.
- R3: A word program changes only the addressed word, which becomes its old value ANDed with data_i.
- R4: A page erase sets to all ones every word whose index divided by PAGE_WORDS equals addr_i divided by PAGE_WORDS. The low address bits are ignored, and other pages keep their contents.
- R5: A general-segment erase sets every word of the array to all ones.
- R6: For an accepted command, busy_o is high from the cycle after start for exactly PROG_CYCLES cycles (program) or ERASE_CYCLES cycles (either erase). In the next cycle busy_o is low and done_o is high for one cycle, and the array already holds the result.
- R7: A rejected command raises done_o and err_o together for exactly one cycle, the cycle after start. busy_o stays low and the array is unchanged.
- R8: A start strobe that arrives while busy_o is high is ignored. It changes neither the running command's timing nor its result, and it raises no error.
- R9: After reset, busy_o, done_o and err_o are low and every array word reads all ones.
- R10: rd_data_o shows the word at rd_addr_i combinationally. err_o is never high outside a done_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command start strobe |
| op_i | input | 4 | Operation code |
| erase_i | input | 1 | Erase flag, selects the code table |
| addr_i | input | AW | Target word address |
| data_i | input | WORD_W | Word to program |
| rd_addr_i | input | AW | Read port address |
| rd_data_o | output | WORD_W | Read port data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejected command, valid with done_o |

## Verification
The assertions assume that PAGE_WORDS is a power of two, that both cycle counts are at least one, and that at most one array action is active at a time. They also assume that start_i is a single-cycle strobe whose command fields are sampled only in the cycle in which it is accepted. The stimulus drives every start for exactly one cycle on the falling edge. It draws addresses only from inside the array, and it waits for done_o before sending the next command, except for the deliberate strobes sent into a busy window.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_PROG = 2'd1,
    ACT_PAGE = 2'd2,
    ACT_SEG  = 2'd3
  } flash_act_e;

  localparam logic [3:0] OPC_PAGE_ERASE = 4'b0010;
  localparam logic [3:0] OPC_SEG_ERASE  = 4'b1101;
  localparam logic [3:0] OPC_WORD_PROG  = 4'b0011;

  function automatic flash_act_e classify(input logic erase, input logic [3:0] op);
    flash_act_e a;
    a = ACT_NONE;
    if (erase) begin
      if (op == OPC_PAGE_ERASE)     a = ACT_PAGE;
      else if (op == OPC_SEG_ERASE) a = ACT_SEG;
    end else if (op == OPC_WORD_PROG) begin
      a = ACT_PROG;
    end
    return a;
  endfunction

  function automatic int unsigned page_of(input int unsigned word_idx,
                                          input int unsigned page_words);
    return word_idx / page_words;
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_seq_pkg::*;
(
  input  logic       erase_i,
  input  logic [3:0] op_i,
  output flash_act_e act_o,
  output logic       valid_o,
  output logic       long_o
);
  always_comb begin
    act_o   = classify(erase_i, op_i);
    valid_o = (act_o != ACT_NONE);
    long_o  = (act_o == ACT_PAGE) || (act_o == ACT_SEG);
  end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned PROG_CYCLES  = 9760,
  parameter int unsigned ERASE_CYCLES = 5300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic long_i,
  input  logic reject_i,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic fire_o
);
  localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (busy_o) begin
        if (cnt_q == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (launch_i) begin
        busy_o <= 1'b1;
        cnt_q  <= long_i ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
      end else if (reject_i) begin
        done_o <= 1'b1;
        err_o  <= 1'b1;
      end
    end
  end

  a_r6_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i && !busy_o |=> busy_o);
  a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_reject_path: assert property (@(posedge clk) disable iff (!rst_n)
    reject_i && !busy_o && !launch_i |=> done_o && err_o && !busy_o);
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o && !busy_o);
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
  import flash_seq_pkg::*;
#(
  parameter int unsigned WORD_W     = 24,
  parameter int unsigned PAGE_WORDS = 512,
  parameter int unsigned PAGES      = 2,
  localparam int unsigned DEPTH     = PAGE_WORDS * PAGES,
  localparam int unsigned AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_i,
  input  logic              page_i,
  input  logic              seg_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  int unsigned       sel_page;

  assign sel_page  = page_of(int'(addr_i), PAGE_WORDS);
  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        mem_q[i] <= '1;
      end else if (seg_i || (page_i && page_of(i, PAGE_WORDS) == sel_page)) begin
        mem_q[i] <= '1;
      end else if (prog_i && (AW'(i) == addr_i)) begin
        mem_q[i] <= mem_q[i] & data_i;
      end
    end
  end

  a_r1_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_i, page_i, seg_i}));
  a_r5_segment_blank: assert property (@(posedge clk) disable iff (!rst_n)
    seg_i |=> (mem_q[0] == '1) && (mem_q[DEPTH-1] == '1));
  a_r3_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    prog_i |=> (rd_addr_i != $past(addr_i)) || ((rd_data_o & ~$past(data_i)) == '0));
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import flash_seq_pkg::*;
#(
  parameter int unsigned WORD_W       = 24,
  parameter int unsigned PAGE_WORDS   = 512,
  parameter int unsigned PAGES        = 2,
  parameter int unsigned PROG_CYCLES  = 9760,
  parameter int unsigned ERASE_CYCLES = 5300000,
  localparam int unsigned AW          = $clog2(PAGE_WORDS * PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3:0]        op_i,
  input  logic              erase_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  flash_act_e        dec_act;
  logic              dec_valid, dec_long;
  logic              accept, launch, reject, fire;
  flash_act_e        act_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] data_q;
  logic              prog_stb, page_stb, seg_stb;

  flash_cmd_decode u_dec (
    .erase_i (erase_i),
    .op_i    (op_i),
    .act_o   (dec_act),
    .valid_o (dec_valid),
    .long_o  (dec_long)
  );

  assign accept = start_i && !busy_o;
  assign launch = accept && dec_valid;
  assign reject = accept && !dec_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= ACT_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (launch) begin
      act_q  <= dec_act;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  flash_busy_timer #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .long_i   (dec_long),
    .reject_i (reject),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .fire_o   (fire)
  );

  assign prog_stb = fire && (act_q == ACT_PROG);
  assign page_stb = fire && (act_q == ACT_PAGE);
  assign seg_stb  = fire && (act_q == ACT_SEG);

  flash_array_model #(
    .WORD_W     (WORD_W),
    .PAGE_WORDS (PAGE_WORDS),
    .PAGES      (PAGES)
  ) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_i    (prog_stb),
    .page_i    (page_stb),
    .seg_i     (seg_stb),
    .addr_i    (addr_q),
    .data_i    (data_q),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  a_r8_busy_start_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> !err_o);
  a_r8_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(act_q) && $stable(addr_q));
  a_r6_strobe_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb || page_stb || seg_stb) |=> !busy_o && done_o && !err_o);
endmodule

// File: tb/sim_flash_op_sequencer.sv
`timescale 1ns/1ps
module sim_flash_op_sequencer;
  localparam int WW = 16;
  localparam int PW = 16;
  localparam int NP = 4;
  localparam int DEPTH = PW * NP;
  localparam int AW = $clog2(DEPTH);
  localparam int PC = 12;
  localparam int EC = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    op_i = '0;
  logic          erase_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [WW-1:0] data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [WW-1:0] rd_data_o;
  logic          busy_o, done_o, err_o;

  int checks = 0;
  int errors = 0;
  logic [WW-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  flash_op_sequencer #(
    .WORD_W(WW), .PAGE_WORDS(PW), .PAGES(NP),
    .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .erase_i(erase_i), .addr_i(addr_i), .data_i(data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // 0 none, 1 word program, 2 page erase, 3 segment erase
  function automatic int exp_kind(input logic er, input logic [3:0] op);
    case ({er, op})
      5'b1_0010: return 2;
      5'b1_1101: return 3;
      5'b0_0011: return 1;
      default:   return 0;
    endcase
  endfunction

  task automatic model_apply(input int kind, input int addr, input logic [WW-1:0] d);
    for (int i = 0; i < DEPTH; i++) begin
      if (kind == 3) model[i] = '1;
      else if (kind == 2 && (i >> $clog2(PW)) == (addr >> $clog2(PW))) model[i] = '1;
      else if (kind == 1 && i == addr) model[i] = model[i] & d;
    end
  endtask

  task automatic cmp_array(input string req);
    int bad = 0;
    int bad_i = 0;
    logic [WW-1:0] got = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr_i = AW'(i);
      #0.1;
      if (rd_data_o !== model[i] && bad == 0) begin
        bad = 1; bad_i = i; got = rd_data_o;
      end
    end
    chk(bad == 0, req, got, bad ? model[bad_i] : got);
  endtask

  task automatic run_cmd(input logic [3:0] op, input logic er, input int addr,
                         input logic [WW-1:0] d, input bit poke);
    int kind = exp_kind(er, op);
    int n = (kind == 1) ? PC : EC;
    int seen = 0;
    bit err_seen = 0;
    @(negedge clk);
    start_i = 1'b1; op_i = op; erase_i = er; addr_i = AW'(addr); data_i = d;
    @(negedge clk);
    start_i = 1'b0;
    if (kind == 0) begin
      chk(done_o && err_o && !busy_o, (er ? "R1 reject" : "R2 reject"),
          {done_o, err_o, busy_o}, 3'b110);
      chk(done_o && err_o && !busy_o, "R7 noop pulse", {done_o, err_o, busy_o}, 3'b110);
      cmp_array("R7 array unchanged");
      @(negedge clk);
      chk(!done_o && !err_o && !busy_o, "R7 one cycle", {done_o, err_o, busy_o}, 3'b000);
    end else begin
      chk(busy_o === 1'b1, "R6 busy after start", busy_o, 1);
      while (busy_o === 1'b1 && seen < n + 4) begin
        seen++;
        if (poke && seen == 2) begin
          start_i = 1'b1; op_i = 4'b1111; erase_i = 1'b1; addr_i = '0; data_i = '0;
        end
        if (err_o) err_seen = 1;
        @(negedge clk);
        start_i = 1'b0;
      end
      chk(seen == n, "R6 busy length", seen, n);
      chk(done_o && !err_o && !busy_o, "R6 done with busy low", {done_o, err_o, busy_o}, 3'b100);
      if (poke) chk(!err_seen, "R8 start while busy ignored", err_seen, 0);
      model_apply(kind, addr, d);
      cmp_array(kind == 1 ? "R3 program" : (kind == 2 ? "R4 page erase" : "R5 segment erase"));
      @(negedge clk);
      chk(!done_o, "R6 done one cycle", done_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R9 reset outputs", {busy_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R9 idle after reset", {busy_o, done_o, err_o}, 0);
    cmp_array("R9 array erased, R10 read port");

    run_cmd(4'b0011, 1'b0, 5, 16'h0F0F, 0);
    run_cmd(4'b0011, 1'b0, 5, 16'hFF00, 0);   // R3: AND gives 0x0F00
    rd_addr_i = AW'(5); #0.1;
    chk(rd_data_o == 16'h0F00, "R3 AND result", rd_data_o, 16'h0F00);
    run_cmd(4'b0011, 1'b0, 21, 16'h1234, 0);
    run_cmd(4'b0001, 1'b0, 21, 16'h0000, 0);  // R2 row code rejected
    run_cmd(4'b0010, 1'b0, 21, 16'h0000, 0);  // R2 erase code without flag
    run_cmd(4'b0011, 1'b1, 21, 16'h0000, 0);  // R1 program code with flag
    run_cmd(4'b1111, 1'b1, 0, 16'h0000, 0);   // R1 former bulk code
    run_cmd(4'b1100, 1'b1, 0, 16'h0000, 0);   // R1 secure-segment code
    run_cmd(4'b0010, 1'b1, 16 + 7, 16'h0, 0); // R4 low bits ignored
    run_cmd(4'b0011, 1'b0, 40, 16'h00FF, 1);  // R8 poke during program
    run_cmd(4'b0011, 1'b0, 63, 16'hA5A5, 0);
    run_cmd(4'b1101, 1'b1, 3, 16'h0, 1);      // R5 with R8 poke

    for (int k = 0; k < 40; k++) begin
      int sel = $urandom % 5;
      int a = $urandom % DEPTH;
      logic [WW-1:0] d = WW'($urandom);
      logic [3:0] op = 4'($urandom);
      logic er = 1'($urandom);
      case (sel)
        0, 1: begin op = 4'b0011; er = 1'b0; end
        2:    begin op = 4'b0010; er = 1'b1; end
        default: ;
      endcase
      run_cmd(op, er, a, d, ($urandom % 4) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule